// File: doc/BRIEF.md
# Power-Fail Store and Recall Sequencer

This block decides when a volatile memory is copied into nonvolatile cells and when it is copied back. It watches two digital supply comparator flags: one is high while the supply sits above the switch threshold, the other is high while the supply is below the lower reset level. It tracks whether the memory has been written since the last nonvolatile cycle. It also drives and reads back a shared open-drain busy line.

On a falling supply it pulls the busy line low for a fixed pulse. It then either runs an erase-then-program store, or releases the line when nothing changed. If an outside driver holds the line high, it abandons the attempt. A drop below the reset level arms a recall. The recall runs a clear-then-transfer sequence once the supply is back above the switch threshold.

The array is modelled by four command strobes, each with a done handshake. All durations are parameters in clock cycles.

States, named as in the RTL:

| State | Meaning | Leaves on |
|---|---|---|
| `ST_IDLE` | Waiting. | A switch fall goes to `ST_PULSE`. An armed recall with the supply good goes to `ST_CLEAR`. |
| `ST_PULSE` | Busy pulled low. | The line reads high at the settle point: back to `ST_IDLE` (abort). At pulse end: `ST_ERASE` if dirty, else `ST_IDLE` (skip). |
| `ST_ERASE` | Erase strobe high. | Erase done goes to `ST_PROG`. Timeout goes to `ST_IDLE`. |
| `ST_PROG` | Program strobe high. | Program done goes to `ST_IDLE` and clears the dirty flag. Timeout goes to `ST_IDLE`. |
| `ST_CLEAR` | Clear strobe high. | Clear done goes to `ST_XFER`. Timeout goes to `ST_IDLE`. |
| `ST_XFER` | Transfer strobe high. | Transfer done goes to `ST_IDLE` and clears the dirty flag. Timeout goes to `ST_IDLE`. |

Top module: `pf_seq`

## Requirements
- R1: A write request is accepted only while `wr_inhibit_o` is low. `wr_inhibit_o` is high whenever the two-stage-synchronized supply-good flag is low, and also during any store or recall. An accepted write sets `dirty_o`; a refused write leaves it unchanged.
- R2: A high-to-low transition of the synchronized supply-good flag drives `busy_pd_o` high for exactly PULSE_CYC cycles. If `dirty_o` is low at that point, the line is then released and no store strobe is issued.
- R3: If `busy_line_i` reads high in the SETTLE_CYC-th cycle of the pulse, `busy_pd_o` drops after exactly SETTLE_CYC cycles. No store follows, and `dirty_o` is kept.
- R4: A store raises `nv_erase_o` until `nv_erase_done_i`, then `nv_prog_o` until `nv_prog_done_i`. `busy_pd_o` stays high from pulse start through program completion. On completion `dirty_o` is cleared.
- R5: A store not finished STORE_MAX cycles after erase starts is given up. `busy_pd_o` is released and `dirty_o` is kept.
- R6: A low-to-high transition of the synchronized below-reset flag arms a recall. Once the supply is good, `mem_clear_o` is held until its done, then `nv_xfer_o` until its done, and `dirty_o` is cleared. A recall not finished in RECALL_MAX cycles is given up.
- R7: A supply dip that never reaches the reset level causes no recall when the supply returns.
- R8: `chip_dis_o` and `wr_inhibit_o` are high in every cycle in which any of the four array strobes is high.
- R9: One supply crossing triggers at most one action. Holding the supply low produces a single busy pulse.
- R10: At most one of the four array strobes is high at a time. After reset all strobes, `busy_pd_o`, `chip_dis_o` and `dirty_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_ok_i | input | 1 | Comparator: supply above switch threshold |
| sup_lost_i | input | 1 | Comparator: supply below reset level |
| mem_wr_req_i | input | 1 | Memory write request, one per cycle |
| busy_line_i | input | 1 | Sampled level of the shared busy line |
| busy_pd_o | output | 1 | Busy line pull-down enable |
| wr_inhibit_o | output | 1 | Memory writes blocked |
| chip_dis_o | output | 1 | Memory reads and writes disabled |
| dirty_o | output | 1 | Memory written since last nonvolatile cycle |
| nv_erase_o | output | 1 | Erase nonvolatile cells |
| nv_erase_done_i | input | 1 | Erase finished |
| nv_prog_o | output | 1 | Program nonvolatile cells from memory |
| nv_prog_done_i | input | 1 | Program finished |
| mem_clear_o | output | 1 | Clear the volatile memory |
| mem_clear_done_i | input | 1 | Clear finished |
| nv_xfer_o | output | 1 | Copy nonvolatile data into memory |
| nv_xfer_done_i | input | 1 | Transfer finished |

## Verification
The bench measures busy pulse lengths in whole cycles. A clean drop must give exactly PULSE_CYC cycles and a blocked line exactly SETTLE_CYC cycles, so an off-by-one timer or a missing abort shows up as a wrong count. A hung array exposes a store that never times out, and a long hold of the supply low exposes a level-triggered design that pulses repeatedly. Shallow dips separate a recall armed by the reset level from one armed by any dip. Random power cycles mix writes, a busy line held high from outside and deep drops, so a design that forgets to keep or clear the dirty flag after an abort, a store or a recall diverges from the bench's model.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_ERASE,
        ST_PROG,
        ST_CLEAR,
        ST_XFER
    } pf_state_e;
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d_i[i];
                s2 <= s1;
            end
        end
        assign q_o[i] = s2;
    end
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
    import pf_pkg::*;
#(
    parameter int PULSE_CYC  = 200,
    parameter int SETTLE_CYC = 4,
    parameter int STORE_MAX  = 2000000,
    parameter int RECALL_MAX = 110000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_fall,
    input  logic recall_go,
    input  logic dirty,
    input  logic busy_line,
    input  logic erase_done,
    input  logic prog_done,
    input  logic clear_done,
    input  logic xfer_done,
    output logic busy_pd,
    output logic nv_busy,
    output logic erase,
    output logic prog,
    output logic clear,
    output logic xfer,
    output logic recall_start,
    output logic op_done
);
    localparam int OP_MAX = (STORE_MAX > RECALL_MAX) ? STORE_MAX : RECALL_MAX;
    localparam int TW = $clog2(PULSE_CYC + 1);
    localparam int OW = $clog2(OP_MAX + 1);
    localparam logic [TW-1:0] PULSE_LAST  = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYC - 1);
    localparam logic [OW-1:0] STORE_LAST  = OW'(STORE_MAX - 1);
    localparam logic [OW-1:0] RECALL_LAST = OW'(RECALL_MAX - 1);

    pf_state_e     state, state_nx;
    logic [TW-1:0] pulse_t;
    logic [OW-1:0] op_t;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pulse_t <= '0;
            op_t    <= '0;
        end else begin
            state   <= state_nx;
            pulse_t <= (state_nx != state) ? '0 : pulse_t + 1'b1;
            op_t    <= (state == ST_IDLE || state == ST_PULSE) ? '0 : op_t + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (sw_fall)        state_nx = ST_PULSE;
                else if (recall_go) state_nx = ST_CLEAR;
            end
            ST_PULSE: begin
                if (pulse_t == SETTLE_LAST && busy_line) state_nx = ST_IDLE;
                else if (pulse_t == PULSE_LAST)          state_nx = dirty ? ST_ERASE : ST_IDLE;
            end
            ST_ERASE: begin
                if (erase_done)              state_nx = ST_PROG;
                else if (op_t == STORE_LAST) state_nx = ST_IDLE;
            end
            ST_PROG: begin
                if (prog_done || op_t == STORE_LAST) state_nx = ST_IDLE;
            end
            ST_CLEAR: begin
                if (clear_done)               state_nx = ST_XFER;
                else if (op_t == RECALL_LAST) state_nx = ST_IDLE;
            end
            ST_XFER: begin
                if (xfer_done || op_t == RECALL_LAST) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_pd      = 1'b0;
        nv_busy      = 1'b0;
        erase        = 1'b0;
        prog         = 1'b0;
        clear        = 1'b0;
        xfer         = 1'b0;
        recall_start = 1'b0;
        op_done      = 1'b0;
        unique case (state)
            ST_IDLE:  recall_start = !sw_fall && recall_go;
            ST_PULSE: busy_pd = 1'b1;
            ST_ERASE: begin
                busy_pd = 1'b1;
                nv_busy = 1'b1;
                erase   = 1'b1;
            end
            ST_PROG: begin
                busy_pd = 1'b1;
                nv_busy = 1'b1;
                prog    = 1'b1;
                op_done = prog_done;
            end
            ST_CLEAR: begin
                nv_busy = 1'b1;
                clear   = 1'b1;
            end
            ST_XFER: begin
                nv_busy = 1'b1;
                xfer    = 1'b1;
                op_done = xfer_done;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pf_seq.sv
module pf_seq #(
    parameter int PULSE_CYC  = 200,
    parameter int SETTLE_CYC = 4,
    parameter int STORE_MAX  = 2000000,
    parameter int RECALL_MAX = 110000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok_i,
    input  logic sup_lost_i,
    input  logic mem_wr_req_i,
    input  logic busy_line_i,
    output logic busy_pd_o,
    output logic wr_inhibit_o,
    output logic chip_dis_o,
    output logic dirty_o,
    output logic nv_erase_o,
    input  logic nv_erase_done_i,
    output logic nv_prog_o,
    input  logic nv_prog_done_i,
    output logic mem_clear_o,
    input  logic mem_clear_done_i,
    output logic nv_xfer_o,
    input  logic nv_xfer_done_i
);
    logic [1:0] flags_s;
    logic       ok_s, lost_s, ok_prev, lost_prev;
    logic       sw_fall, lost_rise;
    logic       dirty_q, recall_pend;
    logic       nv_busy, recall_start, op_done;

    pf_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sup_lost_i, sup_ok_i}),
        .q_o   (flags_s)
    );

    assign ok_s   = flags_s[0];
    assign lost_s = flags_s[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_prev   <= 1'b0;
            lost_prev <= 1'b0;
        end else begin
            ok_prev   <= ok_s;
            lost_prev <= lost_s;
        end
    end

    assign sw_fall   = ok_prev & ~ok_s;
    assign lost_rise = ~lost_prev & lost_s;

    pf_ctrl #(
        .PULSE_CYC  (PULSE_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .STORE_MAX  (STORE_MAX),
        .RECALL_MAX (RECALL_MAX)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_fall      (sw_fall),
        .recall_go    (recall_pend & ok_s),
        .dirty        (dirty_q),
        .busy_line    (busy_line_i),
        .erase_done   (nv_erase_done_i),
        .prog_done    (nv_prog_done_i),
        .clear_done   (mem_clear_done_i),
        .xfer_done    (nv_xfer_done_i),
        .busy_pd      (busy_pd_o),
        .nv_busy      (nv_busy),
        .erase        (nv_erase_o),
        .prog         (nv_prog_o),
        .clear        (mem_clear_o),
        .xfer         (nv_xfer_o),
        .recall_start (recall_start),
        .op_done      (op_done)
    );

    assign chip_dis_o   = nv_busy;
    assign wr_inhibit_o = ~ok_s | nv_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dirty_q     <= 1'b0;
            recall_pend <= 1'b0;
        end else begin
            if (op_done)                            dirty_q <= 1'b0;
            else if (mem_wr_req_i && !wr_inhibit_o) dirty_q <= 1'b1;
            if (lost_rise)         recall_pend <= 1'b1;
            else if (recall_start) recall_pend <= 1'b0;
        end
    end

    assign dirty_o = dirty_q;
endmodule

// File: rtl/pf_seq_chk.sv
module pf_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_wr_req_i,
    input logic busy_pd_o,
    input logic wr_inhibit_o,
    input logic chip_dis_o,
    input logic dirty_o,
    input logic nv_erase_o,
    input logic nv_prog_o,
    input logic mem_clear_o,
    input logic nv_xfer_o
);
    logic any_strobe;
    assign any_strobe = nv_erase_o | nv_prog_o | mem_clear_o | nv_xfer_o;

    assert_dirty_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dirty_o) |-> $past(mem_wr_req_i && !wr_inhibit_o));

    assert_store_needs_dirty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_erase_o) |-> ($past(busy_pd_o) && $past(dirty_o)));

    assert_prog_after_erase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_prog_o) |-> $past(nv_erase_o));

    assert_busy_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_erase_o || nv_prog_o) |-> busy_pd_o);

    assert_xfer_after_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_xfer_o) |-> $past(mem_clear_o));

    assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> (chip_dis_o && wr_inhibit_o));

    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nv_erase_o, nv_prog_o, mem_clear_o, nv_xfer_o}));
endmodule

bind pf_seq pf_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_wr_req_i (mem_wr_req_i),
    .busy_pd_o    (busy_pd_o),
    .wr_inhibit_o (wr_inhibit_o),
    .chip_dis_o   (chip_dis_o),
    .dirty_o      (dirty_o),
    .nv_erase_o   (nv_erase_o),
    .nv_prog_o    (nv_prog_o),
    .mem_clear_o  (mem_clear_o),
    .nv_xfer_o    (nv_xfer_o)
);

// File: tb/sim_pf_seq.sv
`timescale 1ns/1ps
module sim_pf_seq;
    localparam int PULSE  = 8;
    localparam int SETTLE = 3;
    localparam int SMAX   = 64;
    localparam int RMAX   = 48;
    localparam int DLY    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_ok = 1'b0, sup_lost = 1'b1, wr_req = 1'b0, force_hi = 1'b0, hang = 1'b0;
    logic busy_line, busy_pd, wr_inh, chip_dis, dirty;
    logic er, pr, cl, xf;
    logic er_d = 1'b0, pr_d = 1'b0, cl_d = 1'b0, xf_d = 1'b0;
    int   checks = 0, fails = 0;
    int   n_er = 0, n_pr = 0, n_cl = 0, n_xf = 0, n_busy = 0;
    int   c_er = 0, c_pr = 0, c_cl = 0, c_xf = 0;
    logic p_er = 1'b0, p_pr = 1'b0, p_cl = 1'b0, p_xf = 1'b0, p_busy = 1'b0;
    bit   done_flag = 1'b0;

    always #2.5 clk = ~clk;

    assign busy_line = force_hi ? 1'b1 : ~busy_pd;

    pf_seq #(.PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE), .STORE_MAX(SMAX), .RECALL_MAX(RMAX)) u0 (
        .clk(clk), .rst_n(rst_n), .sup_ok_i(sup_ok), .sup_lost_i(sup_lost),
        .mem_wr_req_i(wr_req), .busy_line_i(busy_line), .busy_pd_o(busy_pd),
        .wr_inhibit_o(wr_inh), .chip_dis_o(chip_dis), .dirty_o(dirty),
        .nv_erase_o(er), .nv_erase_done_i(er_d), .nv_prog_o(pr), .nv_prog_done_i(pr_d),
        .mem_clear_o(cl), .mem_clear_done_i(cl_d), .nv_xfer_o(xf), .nv_xfer_done_i(xf_d));

    // array model: each strobe answered with done after DLY cycles unless hung
    always @(negedge clk) begin
        if (er) begin c_er++; er_d = (c_er >= DLY) && !hang; end else begin c_er = 0; er_d = 1'b0; end
        if (pr) begin c_pr++; pr_d = (c_pr >= DLY) && !hang; end else begin c_pr = 0; pr_d = 1'b0; end
        if (cl) begin c_cl++; cl_d = (c_cl >= DLY) && !hang; end else begin c_cl = 0; cl_d = 1'b0; end
        if (xf) begin c_xf++; xf_d = (c_xf >= DLY) && !hang; end else begin c_xf = 0; xf_d = 1'b0; end
        if (er && !p_er) n_er++;
        if (pr && !p_pr) n_pr++;
        if (cl && !p_cl) n_cl++;
        if (xf && !p_xf) n_xf++;
        if (busy_pd && !p_busy) n_busy++;
        p_er = er; p_pr = pr; p_cl = cl; p_xf = xf; p_busy = busy_pd;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_once();
        wr_req = 1'b1;
        step(1);
        wr_req = 1'b0;
        step(1);
    endtask

    // counts cycles with busy_pd high over a window
    task automatic busy_window(input int n, output int cnt, output int dis_cnt);
        cnt = 0;
        dis_cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy_pd) cnt++;
            if (chip_dis) dis_cnt++;
        end
    endtask

    task automatic power_return(input bit deep);
        if (deep) begin
            sup_lost = 1'b1;
            step(6);
            sup_lost = 1'b0;
            step(3);
        end
        sup_ok = 1'b1;
    endtask

    function automatic int exp_store(input bit d, input bit f);
        return (d && !f) ? 1 : 0;
    endfunction

    function automatic bit exp_dirty_end(input bit d, input bit f, input bit deep);
        return d && f && !deep;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int bc, dc, e0, p0, c0, x0, b0;
        bit expd;
        void'($urandom(32'd4242));
        step(3);
        // reset state, R10 and R1
        chk(!busy_pd && !chip_dis && !dirty, "R10 reset outputs", {busy_pd, chip_dis, dirty}, 0);
        chk({er, pr, cl, xf} == 4'b0, "R10 reset strobes", {er, pr, cl, xf}, 0);
        chk(wr_inh == 1'b1, "R1 inhibit in reset", wr_inh, 1);
        rst_n = 1'b1;
        step(5);
        // power-up recall after reset-level excursion (R6)
        c0 = n_cl; x0 = n_xf;
        power_return(1'b0);
        sup_lost = 1'b0;
        step(40);
        chk(n_cl - c0 == 1 && n_xf - x0 == 1, "R6 power-up recall", (n_cl - c0) * 10 + (n_xf - x0), 11);
        chk(!wr_inh, "R1 inhibit released", wr_inh, 0);

        // accepted write sets dirty (R1)
        write_once();
        chk(dirty == 1'b1, "R1 write sets dirty", dirty, 1);

        // shallow dip with dirty: full store (R4, R8), no recall afterwards (R7)
        e0 = n_er; p0 = n_pr; c0 = n_cl;
        sup_ok = 1'b0;
        busy_window(60, bc, dc);
        chk(bc == PULSE + 2 * DLY, "R4 busy held through store", bc, PULSE + 2 * DLY);
        chk(n_er - e0 == 1 && n_pr - p0 == 1, "R4 erase then program", (n_er - e0) * 10 + (n_pr - p0), 11);
        chk(dirty == 1'b0, "R4 store clears dirty", dirty, 0);
        chk(dc == 2 * DLY, "R8 chip disabled during store", dc, 2 * DLY);
        power_return(1'b0);
        step(40);
        chk(n_cl - c0 == 0, "R7 shallow dip no recall", n_cl - c0, 0);

        // clean drop: pulse only (R2), writes refused (R1), single pulse (R9)
        e0 = n_er; b0 = n_busy;
        sup_ok = 1'b0;
        busy_window(40, bc, dc);
        chk(bc == PULSE, "R2 clean pulse length", bc, PULSE);
        chk(n_er - e0 == 0, "R2 clean skips store", n_er - e0, 0);
        chk(wr_inh == 1'b1, "R1 inhibit when supply low", wr_inh, 1);
        write_once();
        chk(dirty == 1'b0, "R1 refused write keeps clean", dirty, 0);
        step(100);
        chk(n_busy - b0 == 1, "R9 one pulse per crossing", n_busy - b0, 1);
        power_return(1'b0);
        step(10);

        // busy line held high outside: abort (R3)
        write_once();
        e0 = n_er;
        force_hi = 1'b1;
        sup_ok = 1'b0;
        busy_window(40, bc, dc);
        chk(bc == SETTLE, "R3 abort pulse length", bc, SETTLE);
        chk(n_er - e0 == 0, "R3 abort no erase", n_er - e0, 0);
        chk(dirty == 1'b1, "R3 abort keeps dirty", dirty, 1);
        force_hi = 1'b0;
        power_return(1'b0);
        step(10);

        // hung array: store timeout (R5)
        hang = 1'b1;
        sup_ok = 1'b0;
        busy_window(120, bc, dc);
        chk(bc == PULSE + SMAX, "R5 store timeout length", bc, PULSE + SMAX);
        chk(dirty == 1'b1, "R5 timeout keeps dirty", dirty, 1);
        // hung recall: timeout (R6)
        sup_lost = 1'b1;
        step(6);
        sup_lost = 1'b0;
        step(3);
        sup_ok = 1'b1;
        busy_window(100, bc, dc);
        chk(dc == RMAX, "R6 recall timeout length", dc, RMAX);
        hang = 1'b0;
        step(5);

        // deep drop with dirty and blocked store: recall clears dirty (R6)
        write_once();
        force_hi = 1'b1;
        sup_ok = 1'b0;
        step(30);
        force_hi = 1'b0;
        c0 = n_cl;
        power_return(1'b1);
        step(40);
        chk(n_cl - c0 == 1 && dirty == 1'b0, "R6 recall clears dirty", (n_cl - c0) * 10 + dirty, 10);

        // constrained random power cycles
        expd = dirty;
        for (int it = 0; it < 24; it++) begin
            bit w, f, deep;
            w = ($urandom % 2) == 1;
            f = ($urandom % 4) == 0;
            deep = ($urandom % 2) == 1;
            if (w) begin
                write_once();
                expd = 1'b1;
            end
            chk(dirty == expd, "R1 random dirty", dirty, expd);
            e0 = n_er; c0 = n_cl;
            force_hi = f;
            sup_ok = 1'b0;
            step(40);
            chk(n_er - e0 == exp_store(expd, f), "R4 random store", n_er - e0, exp_store(expd, f));
            force_hi = 1'b0;
            power_return(deep);
            step(40);
            chk(n_cl - c0 == int'(deep), "R7 random recall", n_cl - c0, int'(deep));
            expd = exp_dirty_end(expd, f, deep);
            chk(dirty == expd, "R6 random dirty end", dirty, expd);
        end

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule